// File: doc/BRIEF.md
# Timer Event and Status-Flag Unit

A 16-bit timer core whose main job is to raise status flags and to run software-triggered events. A counter counts up or down and reloads from an auto-reload value when it reaches the end of its range. A repetition counter decides which of these wraps count as update events. Two channels each act either as an output compare, which flags a counter match, or as an input capture, which latches the counter on an edge of the selected polarity. The update flag can be suppressed, and it can be limited to counter wraps only.

Software reaches the unit through a small word-addressed register port. The port holds the control word, the flag enables, the status flags, a write-only event register, the counter, the auto-reload value, the repetition value and the two channel registers. An event bit written to the event register acts on the next clock and is then gone. An external trigger can reinitialise the counter. A main output enable is set by software and dropped by either of the two break events. The interrupt line is the OR of the enabled flags.

Top module: `tim_evt_unit`

Register addresses: 0 control, 1 flag enable, 2 status, 3 event, 4 counter, 5 auto-reload, 6 repetition, 7 channel 1, 8 channel 2.

Control bits:
- bit0 count enable
- bit1 count down
- bit2 update disable
- bit3 wrap-only update source
- bit4 main output enable
- bit5 and bit6 capture mode for channels 1 and 2
- bit7 and bit8 falling-edge select for channels 1 and 2
- bit9 trigger enable

Flag and event bits:
- bit0 update
- bits 1 to 4 channels 1 to 4
- bit5 commutation
- bit6 trigger
- bit7 break
- bit8 second break

## Requirements
- R1: After reset the control word, counter, flags, repetition value and channel values read 0, the auto-reload value reads 0xFFFF, and irq_o and main_oe_o are low.
- R2: When counting up, the counter steps by one per clock and goes to 0 after it equals the auto-reload value. When counting down, it goes to the auto-reload value after 0.
- R3: A channel in compare mode (control bit 5 or 6 at 0) sets its flag (status bit 1 or 2) one clock after the enabled counter equals its compare value.
- R4: When a compare value is above the auto-reload value, that channel's flag is set on the up-count overflow or the down-count underflow instead.
- R5: A channel in capture mode copies the counter into its register and sets its flag on an input edge of the selected polarity (falling when bit 7 or 8 is 1, rising otherwise). An edge of the other polarity changes nothing.
- R6: A read of a channel register in capture mode clears that channel's flag.
- R7: An overflow or underflow sets the update flag (bit 0) only when the repetition counter is 0 and update disable is 0. Otherwise the repetition counter decrements, and it reloads on every update event.
- R8: Event bit 0 resets the counter (to 0 up, to the auto-reload value down) and reloads the repetition counter. It sets the update flag only when control bits 2 and 3 are both 0.
- R9: A rising external trigger edge with bit 9 set reinitialises the counter like event bit 0, under the same update-flag conditions, and always sets the trigger flag (bit 6).
- R10: Event bits act one clock after the write and then clear themselves. The event register reads 0. Event bits 1 to 6 set the matching flag, and a channel event in capture mode also captures the counter.
- R11: Event bit 7 or 8 clears main_oe_o and sets status bit 7 or 8 respectively.
- R12: Writing the status register clears flags written as 0 and keeps flags written as 1. A hardware set in the same clock wins over the clear.
- R13: irq_o is high exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| addr_i | input | 4 | register word address |
| wr_en_i | input | 1 | register write strobe |
| rd_en_i | input | 1 | register read strobe (side effects only) |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data, combinational from addr_i |
| ext_trig_i | input | 1 | external trigger, synchronous |
| cap_i | input | 2 | capture inputs, one per channel, synchronous |
| flags_o | output | 9 | status flag vector |
| irq_o | output | 1 | interrupt request |
| main_oe_o | output | 1 | main output enable |

## Verification
The bench places a compare value above the auto-reload value. A design that keeps comparing for equality would then never flag that channel on a wrap. It runs the repetition counter with a non-zero reload, so a design that flags every overflow is caught. It issues software and trigger reinitialisations with update disable and with the wrap-only source selected, which exposes an update flag that ignores those qualifiers. It also drives a capture edge in the same clock as a software clear, reads capture registers to check clear-on-read, and applies the wrong edge polarity. A design with the wrong priority loses the flag, and one with the wrong polarity latches a bogus count.

// File: rtl/tim_evt_pkg.sv
package tim_evt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NCH    = 2;
  localparam int FLAG_W = 9;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_EGR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ARR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_REP  = 4'd6;
  localparam int A_CCR_BASE = 7;

  // flag / event bit positions
  localparam int F_UPD  = 0;
  localparam int F_CC   = 1;
  localparam int F_COM  = 5;
  localparam int F_TRG  = 6;
  localparam int F_BRK  = 7;
  localparam int F_BRK2 = 8;

  typedef struct packed {
    logic           trg_en;
    logic [NCH-1:0] cap_fall;
    logic [NCH-1:0] cap_mode;
    logic           moe;
    logic           urs;
    logic           udis;
    logic           dn;
    logic           en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tim_cnt_core.sv
module tim_cnt_core #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dn_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [REP_W-1:0] rep_ld_i,
  input  logic             reinit_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             uev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q;
  logic             at_end;

  assign at_end = dn_i ? (cnt_q == '0) : (cnt_q == arr_i);
  // reinit and software write pre-empt the step
  assign wrap_o = en_i & at_end & ~reinit_i & ~wr_i;
  assign uev_o  = wrap_o & (rep_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reinit_i) begin
      cnt_q <= dn_i ? arr_i : '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (en_i) begin
      if (at_end)    cnt_q <= dn_i ? arr_i : '0;
      else if (dn_i) cnt_q <= cnt_q - CNT_W'(1);
      else           cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
    end else if (reinit_i) begin
      rep_q <= rep_ld_i;
    end else if (wrap_o) begin
      rep_q <= (rep_q == '0) ? rep_ld_i : rep_q - REP_W'(1);
    end
  end
endmodule

// File: rtl/tim_cc_chan.sv
module tim_cc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             cnt_en_i,
  input  logic             wrap_i,
  input  logic             cap_mode_i,
  input  logic             cap_fall_i,
  input  logic             cap_i,
  input  logic             gen_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             set_o
);
  logic [CNT_W-1:0] ccr_q;
  logic             cap_q;
  logic             pol_edge;
  logic             capture;
  logic             hit;

  assign pol_edge = cap_fall_i ? (cap_q & ~cap_i) : (~cap_q & cap_i);
  assign capture  = cap_mode_i & (pol_edge | gen_i);
  // compare above reload: flag on wrap instead of match
  assign hit      = ~cap_mode_i & cnt_en_i &
                    ((ccr_q > arr_i) ? wrap_i : (cnt_i == ccr_q));
  assign set_o    = capture | hit | (gen_i & ~cap_mode_i);
  assign ccr_o    = ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      ccr_q <= '0;
    end else begin
      cap_q <= cap_i;
      if (capture)                 ccr_q <= cnt_i;
      else if (wr_i & ~cap_mode_i) ccr_q <= wdata_i;
    end
  end
endmodule

// File: rtl/tim_flag_bank.sv
module tim_flag_bank #(
  parameter int FLAG_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              sw_wr_i,
  input  logic [FLAG_W-1:0] sw_data_i,
  input  logic [FLAG_W-1:0] rd_clr_i,
  input  logic [FLAG_W-1:0] ien_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] clr;

  assign clr     = (sw_wr_i ? ~sw_data_i : '0) | rd_clr_i;
  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & ien_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr) | set_i;  // set wins
  end
endmodule

// File: rtl/tim_evt_unit.sv
module tim_evt_unit
  import tim_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_trig_i,
  input  logic [NCH-1:0]    cap_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              main_oe_o
);
  ctrl_t             ctrl_q;
  logic [FLAG_W-1:0] ien_q;
  logic [FLAG_W-1:0] egr_q;
  logic [CNT_W-1:0]  arr_q;
  logic [REP_W-1:0]  rep_q;
  logic              trig_q;
  logic              trig_edge;
  logic              reinit;
  logic              wrap;
  logic              uev_wrap;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ccr [NCH];
  logic [NCH-1:0]    ch_set;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] rd_clr;
  logic              brk_any;

  logic wr_ctrl, wr_ien, wr_stat, wr_egr, wr_cnt, wr_arr, wr_rep;
  assign wr_ctrl = wr_en_i & (addr_i == A_CTRL);
  assign wr_ien  = wr_en_i & (addr_i == A_IEN);
  assign wr_stat = wr_en_i & (addr_i == A_STAT);
  assign wr_egr  = wr_en_i & (addr_i == A_EGR);
  assign wr_cnt  = wr_en_i & (addr_i == A_CNT);
  assign wr_arr  = wr_en_i & (addr_i == A_ARR);
  assign wr_rep  = wr_en_i & (addr_i == A_REP);

  assign brk_any   = egr_q[F_BRK] | egr_q[F_BRK2];
  assign trig_edge = ctrl_q.trg_en & ext_trig_i & ~trig_q;
  assign reinit    = egr_q[F_UPD] | trig_edge;
  assign main_oe_o = ctrl_q.moe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      egr_q  <= '0;
      arr_q  <= '1;
      rep_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= ext_trig_i;
      egr_q  <= wr_egr ? wdata_i[FLAG_W-1:0] : '0;  // one-clock pulse
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (brk_any) ctrl_q.moe <= 1'b0;               // break wins
      if (wr_ien)  ien_q <= wdata_i[FLAG_W-1:0];
      if (wr_arr)  arr_q <= wdata_i[CNT_W-1:0];
      if (wr_rep)  rep_q <= wdata_i[REP_W-1:0];
    end
  end

  tim_cnt_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.en),
    .dn_i     (ctrl_q.dn),
    .arr_i    (arr_q),
    .rep_ld_i (rep_q),
    .reinit_i (reinit),
    .wr_i     (wr_cnt),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .cnt_o    (cnt),
    .wrap_o   (wrap),
    .uev_o    (uev_wrap)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic wr_ccr;
    assign wr_ccr = wr_en_i & (addr_i == ADDR_W'(A_CCR_BASE + k));
    assign rd_clr[F_CC+k] = rd_en_i & ctrl_q.cap_mode[k] &
                            (addr_i == ADDR_W'(A_CCR_BASE + k));
    tim_cc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .arr_i      (arr_q),
      .cnt_en_i   (ctrl_q.en),
      .wrap_i     (wrap),
      .cap_mode_i (ctrl_q.cap_mode[k]),
      .cap_fall_i (ctrl_q.cap_fall[k]),
      .cap_i      (cap_i[k]),
      .gen_i      (egr_q[F_CC+k]),
      .wr_i       (wr_ccr),
      .wdata_i    (wdata_i[CNT_W-1:0]),
      .ccr_o      (ccr[k]),
      .set_o      (ch_set[k])
    );
    assign flag_set[F_CC+k] = ch_set[k];
  end

  // event-only channel flags beyond the implemented channels
  for (genvar k = NCH; k < 4; k++) begin : g_ch_evt
    assign flag_set[F_CC+k] = egr_q[F_CC+k];
    assign rd_clr[F_CC+k]   = 1'b0;
  end

  assign rd_clr[F_UPD]  = 1'b0;
  assign rd_clr[F_BRK2:F_COM] = '0;

  assign flag_set[F_UPD]  = ~ctrl_q.udis & (uev_wrap | (reinit & ~ctrl_q.urs));
  assign flag_set[F_COM]  = egr_q[F_COM];
  assign flag_set[F_TRG]  = egr_q[F_TRG] | trig_edge;
  assign flag_set[F_BRK]  = egr_q[F_BRK];
  assign flag_set[F_BRK2] = egr_q[F_BRK2];

  tim_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flag_set),
    .sw_wr_i   (wr_stat),
    .sw_data_i (wdata_i[FLAG_W-1:0]),
    .rd_clr_i  (rd_clr),
    .ien_i     (ien_q),
    .flags_o   (flags_o),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_IEN:   rdata_o[FLAG_W-1:0] = ien_q;
      A_STAT:  rdata_o[FLAG_W-1:0] = flags_o;
      A_CNT:   rdata_o[CNT_W-1:0]  = cnt;
      A_ARR:   rdata_o[CNT_W-1:0]  = arr_q;
      A_REP:   rdata_o[REP_W-1:0]  = rep_q;
      default: begin
        for (int k = 0; k < NCH; k++)
          if (addr_i == ADDR_W'(A_CCR_BASE + k)) rdata_o[CNT_W-1:0] = ccr[k];
      end
    endcase
  end
endmodule

// File: rtl/tim_evt_unit_chk.sv
module tim_evt_unit_chk
  import tim_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] egr_i,
  input logic              urs_i,
  input logic              udis_i,
  input logic              trig_edge_i,
  input logic [FLAG_W-1:0] set_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [FLAG_W-1:0] ien_i,
  input logic              irq_i,
  input logic              moe_i
);
  // R11
  brk_moe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (egr_i[F_BRK] || egr_i[F_BRK2]) |=> !moe_i);

  // R12
  hw_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[F_CC] |=> flags_i[F_CC]);

  // R8
  ug_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (egr_i[F_UPD] && (urs_i || udis_i) && !trig_edge_i) |=> !$rose(flags_i[F_UPD]));

  // R10
  com_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    egr_i[F_COM] |=> flags_i[F_COM]);

  // R13
  irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ien_i) != '0) |-> irq_i);

  // R9
  trig_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_edge_i |=> flags_i[F_TRG]);
endmodule

bind tim_evt_unit tim_evt_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .egr_i       (egr_q),
  .urs_i       (ctrl_q.urs),
  .udis_i      (ctrl_q.udis),
  .trig_edge_i (trig_edge),
  .set_i       (flag_set),
  .flags_i     (flags_o),
  .ien_i       (ien_q),
  .irq_i       (irq_o),
  .moe_i       (main_oe_o)
);

// File: tb/tim_evt_unit_test.sv
module tim_evt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_trig = 1'b0;
  logic [1:0]  cap = '0;
  logic [8:0]  flags;
  logic        irq;
  logic        moe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tim_evt_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .ext_trig_i(ext_trig), .cap_i(cap),
    .flags_o(flags), .irq_o(irq), .main_oe_o(moe)
  );

  localparam logic [1:0] OP_W = 2'd0, OP_P = 2'd1, OP_C = 2'd2;
  localparam logic [3:0] CTRL = 4'd0, IEN = 4'd1, STAT = 4'd2, EGR = 4'd3,
                         CNT = 4'd4, ARR = 4'd5, REP = 4'd6, CCR1 = 4'd7, CCR2 = 4'd8;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [15:0] mask;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    // R1 reset values
    '{OP_P, STAT, 16'h0000, 16'hFFFF, 4'd1},
    '{OP_P, CNT,  16'h0000, 16'hFFFF, 4'd1},
    '{OP_P, ARR,  16'hFFFF, 16'hFFFF, 4'd1},
    '{OP_P, CTRL, 16'h0000, 16'hFFFF, 4'd1},
    '{OP_W, ARR,  16'd9,    16'h0,    4'd0},
    '{OP_W, CCR1, 16'd3,    16'h0,    4'd0},
    '{OP_W, CCR2, 16'd20,   16'h0,    4'd0},
    '{OP_W, CTRL, 16'h0001, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd3,    16'h0,    4'd0},
    // R2 count up
    '{OP_P, CNT,  16'd3,    16'hFFFF, 4'd2},
    // R3 match pending
    '{OP_P, STAT, 16'h0000, 16'h0002, 4'd3},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    '{OP_P, STAT, 16'h0002, 16'h0006, 4'd3},
    '{OP_C, 4'd0, 16'd6,    16'h0,    4'd0},
    '{OP_P, CNT,  16'd0,    16'hFFFF, 4'd2},
    // R4 compare above reload flags at overflow; R7 update at rep 0
    '{OP_P, STAT, 16'h0007, 16'h0007, 4'd4},
    '{OP_W, CTRL, 16'h0000, 16'h0,    4'd0},
    '{OP_W, STAT, 16'hFFF8, 16'h0,    4'd0},
    // R12 write-0 clears
    '{OP_P, STAT, 16'h0000, 16'h01FF, 4'd12},
    '{OP_W, EGR,  16'h0020, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R10 commutation event, event reg reads 0
    '{OP_P, STAT, 16'h0020, 16'h01FF, 4'd10},
    '{OP_P, EGR,  16'h0000, 16'hFFFF, 4'd10},
    '{OP_W, STAT, 16'hFFFF, 16'h0,    4'd0},
    // R12 write-1 keeps
    '{OP_P, STAT, 16'h0020, 16'h01FF, 4'd12},
    '{OP_W, STAT, 16'h0000, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd2,    16'h0,    4'd0},
    // R10 pulse self-clears
    '{OP_P, STAT, 16'h0000, 16'h01FF, 4'd10},
    '{OP_W, REP,  16'd1,    16'h0,    4'd0},
    '{OP_W, CTRL, 16'h0008, 16'h0,    4'd0},
    '{OP_W, CNT,  16'd5,    16'h0,    4'd0},
    '{OP_W, EGR,  16'h0001, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R8 reinit, no flag with wrap-only source
    '{OP_P, CNT,  16'd0,    16'hFFFF, 4'd8},
    '{OP_P, STAT, 16'h0000, 16'h0001, 4'd8},
    '{OP_W, CNT,  16'd9,    16'h0,    4'd0},
    '{OP_W, CTRL, 16'h0009, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R7 rep 1: no update
    '{OP_P, STAT, 16'h0000, 16'h0001, 4'd7},
    '{OP_W, CNT,  16'd9,    16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R7 rep 0: update
    '{OP_P, STAT, 16'h0001, 16'h0001, 4'd7},
    '{OP_W, CTRL, 16'h0000, 16'h0,    4'd0},
    '{OP_W, STAT, 16'h0000, 16'h0,    4'd0},
    '{OP_W, CTRL, 16'h0004, 16'h0,    4'd0},
    '{OP_W, CNT,  16'd5,    16'h0,    4'd0},
    '{OP_W, EGR,  16'h0001, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R8 reinit under update disable
    '{OP_P, CNT,  16'd0,    16'hFFFF, 4'd8},
    '{OP_P, STAT, 16'h0000, 16'h0001, 4'd8},
    '{OP_W, CTRL, 16'h0000, 16'h0,    4'd0},
    '{OP_W, REP,  16'd0,    16'h0,    4'd0},
    '{OP_W, EGR,  16'h0001, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd1,    16'h0,    4'd0},
    // R8 qualified reinit flags
    '{OP_P, STAT, 16'h0001, 16'h0001, 4'd8},
    '{OP_W, STAT, 16'h0000, 16'h0,    4'd0},
    '{OP_W, CNT,  16'd2,    16'h0,    4'd0},
    '{OP_W, CTRL, 16'h0003, 16'h0,    4'd0},
    '{OP_C, 4'd0, 16'd3,    16'h0,    4'd0},
    // R2 down wraps to reload; R4 underflow flag
    '{OP_P, CNT,  16'd9,    16'hFFFF, 4'd2},
    '{OP_P, STAT, 16'h0005, 16'h0007, 4'd4},
    '{OP_W, CTRL, 16'h0000, 16'h0,    4'd0},
    '{OP_W, STAT, 16'h0000, 16'h0,    4'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic peek(input string tag, input logic [3:0] a, input logic [15:0] m,
                      input logic [15:0] e);
    addr = a;
    #1;
    chk(tag, rdata & m, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 moe", {15'd0, moe}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W: wr(VEC[i].addr, VEC[i].data);
        OP_P: peek($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].mask,
                   VEC[i].data);
        default: repeat (VEC[i].data) tick();
      endcase
    end

    // R5 rising capture on channel 1
    wr(CTRL, 16'h0020);
    wr(CNT, 16'd7);
    cap[0] = 1'b1; tick();
    peek("R5 cap value", CCR1, 16'hFFFF, 16'd7);
    peek("R5 cap flag", STAT, 16'h0002, 16'h0002);
    wr(STAT, 16'hFFFD);
    wr(CNT, 16'd2);
    cap[0] = 1'b0; tick();
    peek("R5 wrong edge flag", STAT, 16'h0002, 16'h0000);
    peek("R5 wrong edge value", CCR1, 16'hFFFF, 16'd7);
    // R6 read clears capture flag
    wr(CNT, 16'd4);
    cap[0] = 1'b1; tick();
    addr = CCR1; rd_en = 1'b1; #1;
    chk("R6 read value", rdata, 16'd4);
    tick(); rd_en = 1'b0;
    peek("R6 cleared", STAT, 16'h0002, 16'h0000);
    // R12 capture set beats same-cycle clear
    cap[0] = 1'b0; tick();
    cap[0] = 1'b1; addr = STAT; wdata = 16'h0000; wr_en = 1'b1;
    tick(); wr_en = 1'b0;
    peek("R12 set wins", STAT, 16'h0002, 16'h0002);

    // R5 falling capture on channel 2
    wr(STAT, 16'h0000);
    wr(CTRL, 16'h0140);
    cap[1] = 1'b1; tick();
    peek("R5 ch2 rising ignored", STAT, 16'h0004, 16'h0000);
    wr(CNT, 16'd6);
    cap[1] = 1'b0; tick();
    peek("R5 ch2 value", CCR2, 16'hFFFF, 16'd6);
    peek("R5 ch2 flag", STAT, 16'h0004, 16'h0004);

    // R10 channel event in capture mode
    wr(STAT, 16'h0000);
    wr(CTRL, 16'h0020);
    wr(CNT, 16'd3);
    wr(EGR, 16'h0002);
    tick();
    peek("R10 forced capture", CCR1, 16'hFFFF, 16'd3);
    peek("R10 forced flag", STAT, 16'h0002, 16'h0002);

    // R9 external trigger
    wr(STAT, 16'h0000);
    wr(CTRL, 16'h0200);
    wr(CNT, 16'd5);
    ext_trig = 1'b1; tick();
    peek("R9 trig reinit", CNT, 16'hFFFF, 16'd0);
    peek("R9 trig flags", STAT, 16'h0041, 16'h0041);
    ext_trig = 1'b0; tick();
    wr(CTRL, 16'h0208);
    wr(CNT, 16'd5);
    wr(STAT, 16'h0000);
    ext_trig = 1'b1; tick();
    peek("R9 trig urs reinit", CNT, 16'hFFFF, 16'd0);
    peek("R9 trig urs flags", STAT, 16'h0041, 16'h0040);
    ext_trig = 1'b0;

    // R11 break events
    wr(CTRL, 16'h0010);
    chk("R11 moe set", {15'd0, moe}, 16'd1);
    wr(EGR, 16'h0080);
    tick();
    chk("R11 brk moe", {15'd0, moe}, 16'd0);
    peek("R11 brk flag", STAT, 16'h0080, 16'h0080);
    wr(CTRL, 16'h0010);
    wr(EGR, 16'h0100);
    tick();
    chk("R11 brk2 moe", {15'd0, moe}, 16'd0);
    peek("R11 brk2 flag", STAT, 16'h0100, 16'h0100);

    // R13 interrupt
    wr(STAT, 16'h0000);
    wr(IEN, 16'h0080);
    chk("R13 idle", {15'd0, irq}, 16'd0);
    wr(EGR, 16'h0080);
    tick();
    chk("R13 enabled flag", {15'd0, irq}, 16'd1);
    wr(IEN, 16'h0001);
    chk("R13 masked flag", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule